// File: doc/BRIEF.md
# Error interrupt capture unit

This block gathers single-cycle error pulses from a queue-manager datapath into a sticky status register and drives a level interrupt while any status bit that software has enabled is set. Each recognised error kind has a fixed bit position. Bits that carry no error kind are dropped on entry.

The unit also keeps a snapshot of the first error that reaches it while its capture path is armed. The snapshot holds the error bits of that cycle and the portal and queue context supplied with the pulse. When the error is an ECC fault, it also holds the memory ID and the faulting entry address. Which context fields are filled depends on the class of the error. Fields that do not apply to the captured class read as zero. The snapshot stays frozen until software writes the capture-status value back, one-to-clear. Once that register reads zero, the capture path is armed again.

Software uses a single-cycle 32-bit register bus to program the enable mask, acknowledge status bits, read the snapshot and rearm it. Read data is registered.

Top module: `err_capture_unit`

## Requirements
- R1: A synchronous reset clears the enable, status, capture-status, capture-info and capture-address registers, the read data and the interrupt. All of them read zero after reset.
- R2: A pulse on a defined error bit sets that status bit on the next clock edge. Defined bits are 29..23, 17, 16, 11..8 and 4..0. Pulses on any other bit position are ignored, and those status bits always read zero.
- R3: The status register is write-one-to-clear at word address 1. If a pulse sets a bit in the same cycle as a write clears it, the bit stays set.
- R4: `irq` is a registered output. It is high in the cycle after a cycle in which the status AND enable is non-zero, and low otherwise.
- R5: The enable register at word address 0 is read/write. It keeps only the defined error bits.
- R6: While capture-status is zero, the first cycle with any defined error pulse loads capture-status with exactly the defined error bits of that cycle.
- R7: Capture-info is at word address 3. Bit 29 holds the portal type (1 = direct-connect portal, 0 = software portal), bits 28:24 the portal number and bits 23:0 the queue ID. The portal fields are filled only when the captured bits include one of bits 0, 2, 3, 8, 9, 10, 11, 16 or 17. The queue ID is filled only when they include one of bits 0, 1, 2, 3, 8, 10 or 17. Fields that are not filled read zero.
- R8: Capture-address is at word address 4. Bits 27:24 hold the memory ID and bits 11:0 the entry address. Both are filled only when the captured bits include bit 24 or bit 25. Otherwise the whole word reads zero.
- R9: While capture-status is non-zero, new error pulses still set status bits. Capture-status, capture-info and capture-address do not change unless software writes to capture-status.
- R10: Capture-status at word address 2 is write-one-to-clear. Writing back the value read from it returns it to zero, and the next error pulse is captured again.
- R11: A read issued in one cycle presents its data on `bus_rdata` in the next cycle. Word addresses 5..7 read zero. Writes to capture-info, capture-address or unused addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_pulse | input | 32 | Error event pulses, one bit per error kind |
| err_dc_portal | input | 1 | Portal type of the erroring access, 1 = direct-connect |
| err_portal_num | input | 5 | Portal number of the erroring access |
| err_queue_id | input | 24 | Queue ID of the erroring access |
| err_mem_id | input | 4 | Memory ID of an ECC fault |
| err_mem_addr | input | 12 | Entry address of an ECC fault |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the context inputs are valid in the same cycle as the pulse they describe. They also assume that a capture-status write that lands while the capture path is armed has no work to do. Both assumptions hold by construction of the stimulus, because the bench drives fresh context alongside every pulse and issues at most one bus access per cycle. The random phase mixes sparse multi-bit pulses, including undefined bit positions, with random enables, status clears and write-backs of the modelled capture-status. Directed steps cover a set and a clear of the same bit in one cycle, a capture of ECC-class errors and a capture of portal-class errors, and rearming.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 3;
  localparam int PNUM_W    = 5;
  localparam int QID_W     = 24;
  localparam int MEMID_W   = 4;
  localparam int MADDR_W   = 12;

  // field positions that software decodes
  localparam int INFO_TYPE_BIT  = 29;
  localparam int INFO_PNUM_LSB  = 24;
  localparam int CADDR_MEM_LSB  = 24;

  // error classes
  localparam logic [REG_W-1:0] ERR_DEFINED = 32'h3F83_0F1F;
  localparam logic [REG_W-1:0] ERR_PORTAL  = 32'h0003_0F0D;
  localparam logic [REG_W-1:0] ERR_QUEUE   = 32'h0002_050F;
  localparam logic [REG_W-1:0] ERR_ECC     = 32'h0300_0000;

  typedef enum logic [ADDR_W-1:0] {
    RA_ENABLE = 3'd0,
    RA_STATUS = 3'd1,
    RA_CSTAT  = 3'd2,
    RA_CINFO  = 3'd3,
    RA_CADDR  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/ecu_status_bank.sv
module ecu_status_bank #(
  parameter int                W    = 32,
  parameter logic [W-1:0]      MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)           bit_q <= 1'b0;
        else if (set_i[i]) bit_q <= 1'b1;   // a new event beats a clear
        else if (clr_i[i]) bit_q <= 1'b0;
      end
      assign status_o[i] = bit_q;
    end else begin : g_dead
      assign status_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ecu_capture.sv
module ecu_capture
  import ecu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [REG_W-1:0]   err_i,
  input  logic               rearm_we,
  input  logic [REG_W-1:0]   rearm_data,
  input  logic               dc_portal,
  input  logic [PNUM_W-1:0]  portal_num,
  input  logic [QID_W-1:0]   queue_id,
  input  logic [MEMID_W-1:0] mem_id,
  input  logic [MADDR_W-1:0] mem_addr,
  output logic [REG_W-1:0]   cstat_o,
  output logic [REG_W-1:0]   cinfo_o,
  output logic [REG_W-1:0]   caddr_o
);
  logic [REG_W-1:0] cstat_q, cinfo_q, caddr_q;
  logic [REG_W-1:0] info_nxt, addr_nxt;
  logic             armed, hit;

  assign armed = (cstat_q == '0);
  assign hit   = |err_i;

  always_comb begin
    info_nxt = '0;
    addr_nxt = '0;
    if (|(err_i & ERR_PORTAL)) begin
      info_nxt[INFO_TYPE_BIT]                = dc_portal;
      info_nxt[INFO_PNUM_LSB +: PNUM_W]      = portal_num;
    end
    if (|(err_i & ERR_QUEUE))
      info_nxt[QID_W-1:0]                    = queue_id;
    if (|(err_i & ERR_ECC)) begin
      addr_nxt[CADDR_MEM_LSB +: MEMID_W]     = mem_id;
      addr_nxt[MADDR_W-1:0]                  = mem_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cstat_q <= '0;
      cinfo_q <= '0;
      caddr_q <= '0;
    end else if (armed && hit) begin
      cstat_q <= err_i;
      cinfo_q <= info_nxt;
      caddr_q <= addr_nxt;
    end else if (rearm_we) begin
      cstat_q <= cstat_q & ~rearm_data;
    end
  end

  assign cstat_o = cstat_q;
  assign cinfo_o = cinfo_q;
  assign caddr_o = caddr_q;
endmodule

// File: rtl/err_capture_unit.sv
module err_capture_unit
  import ecu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [REG_W-1:0]   err_pulse,
  input  logic               err_dc_portal,
  input  logic [PNUM_W-1:0]  err_portal_num,
  input  logic [QID_W-1:0]   err_queue_id,
  input  logic [MEMID_W-1:0] err_mem_id,
  input  logic [MADDR_W-1:0] err_mem_addr,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq
);
  logic [REG_W-1:0] err_live, status_q, enable_q, st_clr;
  logic [REG_W-1:0] cstat, cinfo, caddr, rd_mux, rdata_q;
  logic             wr, rd, cstat_we, irq_q;

  assign err_live = err_pulse & ERR_DEFINED;
  assign wr       = bus_en &  bus_we;
  assign rd       = bus_en & ~bus_we;
  assign st_clr   = (wr && bus_addr == RA_STATUS) ? bus_wdata : '0;
  assign cstat_we = wr && bus_addr == RA_CSTAT;

  ecu_status_bank #(.W(REG_W), .MASK(ERR_DEFINED)) u_status (
    .clk(clk), .rst(rst), .set_i(err_live), .clr_i(st_clr), .status_o(status_q)
  );

  ecu_capture u_capture (
    .clk(clk), .rst(rst), .err_i(err_live),
    .rearm_we(cstat_we), .rearm_data(bus_wdata),
    .dc_portal(err_dc_portal), .portal_num(err_portal_num),
    .queue_id(err_queue_id), .mem_id(err_mem_id), .mem_addr(err_mem_addr),
    .cstat_o(cstat), .cinfo_o(cinfo), .caddr_o(caddr)
  );

  always_ff @(posedge clk) begin
    if (rst)                            enable_q <= '0;
    else if (wr && bus_addr == RA_ENABLE) enable_q <= bus_wdata & ERR_DEFINED;
  end

  always_comb begin
    case (bus_addr)
      RA_ENABLE: rd_mux = enable_q;
      RA_STATUS: rd_mux = status_q;
      RA_CSTAT:  rd_mux = cstat;
      RA_CINFO:  rd_mux = cinfo;
      RA_CADDR:  rd_mux = caddr;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_mux;
      irq_q <= |(status_q & enable_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/err_capture_unit_chk.sv
module err_capture_unit_chk
  import ecu_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] err_pulse,
  input logic             wr_cstat,
  input logic [REG_W-1:0] status,
  input logic [REG_W-1:0] enable,
  input logic [REG_W-1:0] cstat,
  input logic [REG_W-1:0] cinfo,
  input logic [REG_W-1:0] caddr,
  input logic             irq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status == '0 && enable == '0 && cstat == '0 && !irq));

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    |(err_pulse & ERR_DEFINED) |=>
      ((status & $past(err_pulse & ERR_DEFINED)) == $past(err_pulse & ERR_DEFINED)));

  // R4
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(status & enable))));

  // R6
  first_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cstat == '0 && |(err_pulse & ERR_DEFINED)) |=>
      (cstat == $past(err_pulse & ERR_DEFINED)));

  // R8
  addr_non_ecc_chk: assert property (@(posedge clk) disable iff (rst)
    (cstat == '0 && |(err_pulse & ERR_DEFINED) && !(|(err_pulse & ERR_ECC))) |=>
      (caddr == '0));

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (cstat != '0 && !wr_cstat) |=>
      ($stable(cstat) && $stable(cinfo) && $stable(caddr)));
endmodule

bind err_capture_unit err_capture_unit_chk u_chk (
  .clk(clk), .rst(rst), .err_pulse(err_pulse),
  .wr_cstat(bus_en && bus_we && bus_addr == RA_CSTAT),
  .status(status_q), .enable(enable_q),
  .cstat(cstat), .cinfo(cinfo), .caddr(caddr), .irq(irq)
);

// File: tb/test_err_capture_unit.sv
`timescale 1ns/1ps
module test_err_capture_unit;
  import ecu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] err_pulse = '0;
  logic        err_dc_portal = 1'b0;
  logic [4:0]  err_portal_num = '0;
  logic [23:0] err_queue_id = '0;
  logic [3:0]  err_mem_id = '0;
  logic [11:0] err_mem_addr = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0, n_err = 0;

  // bench model of the registers
  logic [31:0] m_st = '0, m_en = '0, m_cs = '0, m_ci = '0, m_ca = '0, m_rd = '0;
  logic        m_irq = 1'b0;

  always #2.5 clk = ~clk;

  err_capture_unit i_err_capture_unit (
    .clk(clk), .rst(rst), .err_pulse(err_pulse),
    .err_dc_portal(err_dc_portal), .err_portal_num(err_portal_num),
    .err_queue_id(err_queue_id), .err_mem_id(err_mem_id), .err_mem_addr(err_mem_addr),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // R7: portal fields for bits 0,2,3,8-11,16,17; queue ID for bits 0-3,8,10,17
  function automatic logic [31:0] f_info(logic [31:0] e);
    logic [31:0] v = '0;
    if ((e & 32'h0003_0F0D) != 0) begin
      v[29] = err_dc_portal;
      v[28:24] = err_portal_num;
    end
    if ((e & 32'h0002_050F) != 0) v[23:0] = err_queue_id;
    return v;
  endfunction

  // R8: memory ID 27:24, address 11:0 for bits 24/25
  function automatic logic [31:0] f_addr(logic [31:0] e);
    logic [31:0] v = '0;
    if ((e & 32'h0300_0000) != 0) begin
      v[27:24] = err_mem_id;
      v[11:0] = err_mem_addr;
    end
    return v;
  endfunction

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock of stimulus, model update and port checks
  task automatic cyc(logic [31:0] e, logic en, logic we, logic [2:0] a,
                     logic [31:0] wd, string tag);
    logic [31:0] nst, nen, ncs, nci, nca, nrd, ed;
    logic        nirq, rdo;
    err_pulse = e; bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
    ed   = e & 32'h3F83_0F1F;
    rdo  = en && !we;
    nirq = |(m_st & m_en);
    nrd  = m_rd;
    if (rdo) begin
      case (a)
        3'd0: nrd = m_en;
        3'd1: nrd = m_st;
        3'd2: nrd = m_cs;
        3'd3: nrd = m_ci;
        3'd4: nrd = m_ca;
        default: nrd = '0;
      endcase
    end
    nst = (m_st & ~((en && we && a == 3'd1) ? wd : 32'h0)) | ed;
    nen = (en && we && a == 3'd0) ? (wd & 32'h3F83_0F1F) : m_en;
    ncs = m_cs; nci = m_ci; nca = m_ca;
    if (m_cs == 0 && ed != 0) begin
      ncs = ed; nci = f_info(ed); nca = f_addr(ed);
    end else if (en && we && a == 3'd2) begin
      ncs = m_cs & ~wd;
    end
    @(posedge clk);
    m_st = nst; m_en = nen; m_cs = ncs; m_ci = nci; m_ca = nca; m_rd = nrd; m_irq = nirq;
    @(negedge clk);
    err_pulse = '0; bus_en = 1'b0; bus_we = 1'b0;
    check32("R4", "irq", {31'h0, irq}, {31'h0, m_irq});
    if (rdo) check32(tag, $sformatf("rdata@%0d", a), bus_rdata, m_rd);
  endtask

  task automatic rd(logic [2:0] a, string tag);
    cyc(32'h0, 1'b1, 1'b0, a, 32'h0, tag);
  endtask
  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    cyc(32'h0, 1'b1, 1'b1, a, d, tag);
  endtask
  task automatic pulse(logic [31:0] e, string tag);
    cyc(e, 1'b0, 1'b0, 3'd0, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    check32("R1", "irq after reset", {31'h0, irq}, 32'h0);
    check32("R1", "rdata after reset", bus_rdata, 32'h0);
    for (int a = 0; a < 5; a++) rd(3'(a), "R1");

    // R5: enable keeps defined bits
    wr(3'd0, 32'hFFFF_FFFF, "R5");
    rd(3'd0, "R5");
    check32("R5", "enable value", bus_rdata, 32'h3F83_0F1F);

    // R6/R7: portal-class capture
    err_dc_portal = 1'b1; err_portal_num = 5'd5; err_queue_id = 24'hABCDE;
    err_mem_id = 4'd3; err_mem_addr = 12'h123;
    pulse(32'h0000_0001, "R6");
    rd(3'd2, "R6");
    check32("R6", "cstat bit0", bus_rdata, 32'h1);
    rd(3'd3, "R7");
    check32("R7", "cinfo portal+qid", bus_rdata, 32'h250A_BCDE);
    rd(3'd1, "R2");

    // R9: frozen while non-zero
    err_queue_id = 24'h111111;
    pulse(32'h0100_0000, "R9");
    rd(3'd2, "R9");
    check32("R9", "cstat frozen", bus_rdata, 32'h1);
    rd(3'd4, "R9");
    rd(3'd1, "R9");
    check32("R9", "status still sets", bus_rdata, 32'h0100_0001);

    // R10: rearm by write-back, then ECC capture (R8) with empty info (R7)
    wr(3'd2, 32'h1, "R10");
    rd(3'd2, "R10");
    check32("R10", "cstat rearmed", bus_rdata, 32'h0);
    pulse(32'h0100_0000, "R10");
    rd(3'd2, "R10");
    rd(3'd4, "R8");
    check32("R8", "caddr ecc", bus_rdata, 32'h0300_0123);
    rd(3'd3, "R7");
    check32("R7", "cinfo empty for ecc", bus_rdata, 32'h0);

    // R3: set beats clear in the same cycle
    pulse(32'h0400_0000, "R3");
    cyc(32'h0400_0000, 1'b1, 1'b1, 3'd1, 32'h0400_0000, "R3");
    rd(3'd1, "R3");
    check32("R3", "set wins", bus_rdata & 32'h0400_0000, 32'h0400_0000);

    // R2: undefined bits ignored
    pulse(32'h8000_0040, "R2");
    rd(3'd1, "R2");
    check32("R2", "undefined bits", bus_rdata & 32'hC07C_F0E0, 32'h0);

    // R3: clear all
    wr(3'd1, 32'hFFFF_FFFF, "R3");
    rd(3'd1, "R3");
    check32("R3", "all cleared", bus_rdata, 32'h0);

    // R11: read-only/unused addresses
    wr(3'd3, 32'hFFFF_FFFF, "R11");
    wr(3'd4, 32'hFFFF_FFFF, "R11");
    rd(3'd3, "R11");
    rd(3'd4, "R11");
    rd(3'd7, "R11");
    check32("R11", "unused addr", bus_rdata, 32'h0);

    // R4: disabled source keeps irq low
    wr(3'd0, 32'h0, "R4");
    pulse(32'h0000_0100, "R4");
    pulse(32'h0, "R4");
    check32("R4", "irq masked", {31'h0, irq}, 32'h0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] e;
      int op;
      e = ($urandom % 4 == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
      err_dc_portal = 1'($urandom);
      err_portal_num = 5'($urandom);
      err_queue_id = 24'($urandom);
      err_mem_id = 4'($urandom);
      err_mem_addr = 12'($urandom);
      op = int'($urandom % 8);
      case (op)
        0, 1, 2, 3: cyc(e, 1'b1, 1'b0, 3'($urandom), 32'h0, "R11");
        4: cyc(e, 1'b1, 1'b1, 3'd0, $urandom, "R5");
        5: cyc(e, 1'b1, 1'b1, 3'd1, $urandom, "R3");
        6: cyc(e, 1'b1, 1'b1, 3'd2, m_cs, "R10");
        default: cyc(e, 1'b0, 1'b0, 3'd0, 32'h0, "R9");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule